// File: doc/BRIEF.md
# Precision-Reconfigurable Matrix Product Engine

The engine multiplies two square matrices of unsigned elements. It does this with one fixed grid of 4x4-bit multipliers. The operand width is `SIZE` bits, 16 by default. A precision code picks the element width `b` (4, 8 or 16 bits), and the matrix dimension follows as `h = SIZE/b`. The same sixteen small multipliers then serve as sixteen independent 4-bit products, as four 8-bit products, or as one full 16x16-bit product. No multiplier is idle at any precision.

A product begins with a start pulse. The start pulse clears every accumulator and latches the precision code. After that, each accepted cycle delivers column `k` of X and row `k` of Y, and the engine adds their outer product into the accumulators. The small products are registered in a first stage. A second stage shifts and sums them according to the latched precision, and then adds the result into one accumulator lane per result element. When the last pair has been summed, a one-cycle done pulse marks the result as final.

Top module: `mmx_engine`

## Requirements
- R1: After reset, `done_o` is low and every lane of `res_o` is zero. A `valid_i` pair presented before the first start pulse changes nothing.
- R2: The precision code `prec_i` selects the element width: 0 means b=4 (h=4), 1 means b=8 (h=2), and 2 or 3 mean b=16 (h=1). Element `i` of `x_col_i` and of `y_row_i` sits at bits `[i*b +: b]`.
- R3: Each lane of `res_o` is 32 bits wide. Lane `r*h+c` holds the unsigned sum over `k` of X[r][k]·Y[k][c], zero-extended and without overflow. Lanes at index h·h and above read zero.
- R4: A start pulse clears all lanes and latches `prec_i`. A `valid_i` in the same cycle as the start pulse is taken as the first pair of the new product.
- R5: Let the h-th accepted pair be sampled at clock edge E. Then `done_o` is high for exactly the one cycle after edge E+1, and `res_o` holds the final result from that point on.
- R6: `prec_i` has no effect in any cycle without a start pulse.
- R7: Once h pairs have been accepted, further `valid_i` pairs are ignored until the next start pulse. The result stays unchanged and no new done pulse appears.
- R8: Pairs may arrive with idle cycles between them. The result is the same as for back-to-back pairs.
- R9: A start pulse during an unfinished product abandons it, including a pair still in the pipeline. Only the pairs of the new product contribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new product: clear lanes, latch precision |
| prec_i | input | 2 | Precision code, sampled only with `start_i` |
| valid_i | input | 1 | Qualifies the column/row pair this cycle |
| x_col_i | input | 16 | One column of X, h packed elements |
| y_row_i | input | 16 | One row of Y, h packed elements |
| done_o | output | 1 | One-cycle pulse: result final |
| res_o | output | 512 | 16 lanes of 32 bits, lane r*h+c |

## Verification
Two events can coincide in one cycle. The first is a start pulse together with an accepted pair. The second is a start pulse while the previous product's last pair is still in the first pipeline stage. The bench provokes the first by asserting `start_i` and `valid_i` together on every precision, including h=1, where that one pair is the whole product. It provokes the second by issuing a fresh start one cycle after a stray pair. In both cases the result lanes are compared with a product computed arithmetically in the bench from the new matrices only, and `done_o` must pulse exactly once.

// File: rtl/mmx_pkg.sv
package mmx_pkg;
  localparam int unsigned NIB = 4;
  localparam int unsigned PPW = 2 * NIB;

  // precision codes beyond the widest mode fall back to the widest mode
  function automatic int unsigned clamp_mode(input int unsigned code, input int unsigned nmode);
    return (code >= nmode) ? nmode - 1 : code;
  endfunction
endpackage

// File: rtl/mmx_nibble_grid.sv
module mmx_nibble_grid
  import mmx_pkg::*;
#(
  parameter int unsigned NG = 4
) (
  input  logic [NG*NIB-1:0]      x_i,
  input  logic [NG*NIB-1:0]      y_i,
  output logic [NG*NG*PPW-1:0]   pp_o
);
  for (genvar i = 0; i < NG; i++) begin : g_row
    for (genvar j = 0; j < NG; j++) begin : g_col
      assign pp_o[(i*NG+j)*PPW +: PPW] = {4'b0, x_i[i*NIB +: NIB]} * {4'b0, y_i[j*NIB +: NIB]};
    end
  end
endmodule

// File: rtl/mmx_combine.sv
module mmx_combine
  import mmx_pkg::*;
#(
  parameter int unsigned NG    = 4,
  parameter int unsigned NMODE = 3,
  parameter int unsigned MW    = 2,
  parameter int unsigned ACC_W = 32,
  localparam int unsigned NLANE = NG * NG
) (
  input  logic [NLANE*PPW-1:0]   pp_i,
  input  logic [MW-1:0]          mode_i,
  output logic [NLANE*ACC_W-1:0] sum_o
);
  logic [ACC_W-1:0] var_w [NMODE][NLANE];

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    localparam int unsigned NB   = 1 << m;
    localparam int unsigned HH   = NG >> m;
    localparam int unsigned USED = HH * HH;
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      if (l < USED) begin : g_used
        localparam int unsigned R = l / HH;
        localparam int unsigned C = l % HH;
        logic [ACC_W-1:0] lane_s;
        always_comb begin
          lane_s = '0;
          for (int a = 0; a < NB; a++) begin
            for (int d = 0; d < NB; d++) begin
              lane_s = lane_s + (ACC_W'(pp_i[((R*NB+a)*NG + C*NB + d)*PPW +: PPW]) << (NIB*(a+d)));
            end
          end
        end
        assign var_w[m][l] = lane_s;
      end else begin : g_idle
        assign var_w[m][l] = '0;
      end
    end
  end

  always_comb begin
    sum_o = '0;
    for (int l = 0; l < NLANE; l++) begin
      for (int m = 0; m < NMODE; m++) begin
        if (mode_i == MW'(m)) sum_o[l*ACC_W +: ACC_W] = var_w[m][l];
      end
    end
  end
endmodule

// File: rtl/mmx_accum.sv
module mmx_accum #(
  parameter int unsigned NLANE = 16,
  parameter int unsigned ACC_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   add_i,
  input  logic [NLANE*ACC_W-1:0] sum_i,
  output logic [NLANE*ACC_W-1:0] acc_o
);
  logic [NLANE*ACC_W-1:0] acc_q, acc_n;
  logic                   acc_en;

  assign acc_en = clr_i | add_i;

  always_comb begin
    acc_n = '0;
    if (!clr_i) begin
      for (int l = 0; l < NLANE; l++) begin
        acc_n[l*ACC_W +: ACC_W] = acc_q[l*ACC_W +: ACC_W] + sum_i[l*ACC_W +: ACC_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_n;
  end

  assign acc_o = acc_q;

  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_o == '0));
endmodule

// File: rtl/mmx_engine.sv
module mmx_engine
  import mmx_pkg::*;
#(
  parameter int unsigned SIZE = 16,
  localparam int unsigned NG    = SIZE / NIB,
  localparam int unsigned NLANE = NG * NG,
  localparam int unsigned NMODE = $clog2(NG) + 1,
  localparam int unsigned MW    = (NMODE > 1) ? $clog2(NMODE) : 1,
  localparam int unsigned ACC_W = 2 * SIZE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [MW-1:0]          prec_i,
  input  logic                   valid_i,
  input  logic [SIZE-1:0]        x_col_i,
  input  logic [SIZE-1:0]        y_row_i,
  output logic                   done_o,
  output logic [NLANE*ACC_W-1:0] res_o
);
  localparam int unsigned CW = $clog2(NG + 1) + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // control
  logic [MW-1:0]        mode_q, mode_n;
  logic [CW-1:0]        cnt_q, cnt_n, h_cur, h_new;
  logic                 accept, last_n;
  logic                 pp_v_q, pp_last_q, done_q, done_n;
  logic [NLANE*PPW-1:0] pp_w, pp_q;
  logic [NLANE*ACC_W-1:0] sum_w;

  assign h_cur = CW'(NG >> mode_q);

  always_comb begin
    mode_n = start_i ? MW'(clamp_mode(int'(prec_i), NMODE)) : mode_q;
    h_new  = CW'(NG >> mode_n);
    accept = valid_i & (start_i | (cnt_q < h_cur));
    if (start_i)     cnt_n = valid_i ? CW'(1) : '0;
    else if (accept) cnt_n = cnt_q + CW'(1);
    else             cnt_n = cnt_q;
    last_n = accept & (cnt_n == h_new);
    done_n = ~start_i & pp_v_q & pp_last_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      cnt_q     <= CW'(NG);
      pp_v_q    <= 1'b0;
      pp_last_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      mode_q    <= mode_n;
      cnt_q     <= cnt_n;
      pp_v_q    <= accept;
      pp_last_q <= last_n;
      done_q    <= done_n;
    end
  end

  // stage 1: small-multiplier outputs captured on acceptance
  mmx_nibble_grid #(.NG(NG)) u_grid (
    .x_i  (x_col_i),
    .y_i  (y_row_i),
    .pp_o (pp_w)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     pp_q <= '0;
    else if (accept) pp_q <= pp_w;
  end

  // stage 2: precision-dependent assembly, then accumulation
  mmx_combine #(.NG(NG), .NMODE(NMODE), .MW(MW), .ACC_W(ACC_W)) u_comb (
    .pp_i   (pp_q),
    .mode_i (mode_q),
    .sum_o  (sum_w)
  );

  mmx_accum #(.NLANE(NLANE), .ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_ni),
    .clr_i (start_i),
    .add_i (pp_v_q),
    .sum_i (sum_w),
    .acc_o (res_o)
  );

  assign done_o = done_q;

  assert_prec_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !start_i |=> $stable(mode_q));

  assert_ignore_full_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid_i && !start_i && (cnt_q >= h_cur)) |=> !pp_v_q);

  assert_done_follows_last_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (pp_v_q && pp_last_q && !start_i) |=> done_o);

  assert_done_needs_last_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(done_o) |-> $past(pp_last_q));
endmodule

// File: tb/mmx_engine_tb.sv
module mmx_engine_tb;
  localparam int PERIOD = 10;
  localparam int WD     = 100000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i, valid_i;
  logic [1:0]   prec_i;
  logic [15:0]  x_col_i, y_row_i;
  logic         done_o;
  logic [511:0] res_o;

  int checks = 0;
  int errors = 0;
  int xm [4][4];
  int ym [4][4];
  longint expv [16];

  always #(PERIOD/2) clk = ~clk;

  mmx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prec_i(prec_i), .valid_i(valid_i),
    .x_col_i(x_col_i), .y_row_i(y_row_i), .done_o(done_o), .res_o(res_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint lane(input int l);
    return longint'(res_o[l*32 +: 32]);
  endfunction

  function automatic int width_of(input int code);
    return (code == 0) ? 4 : (code == 1) ? 8 : 16;
  endfunction

  task automatic drive_pair(input int k, input int b, input int h);
    x_col_i = '0;
    y_row_i = '0;
    for (int r = 0; r < h; r++) begin
      x_col_i = x_col_i | 16'(xm[r][k] << (r*b));
      y_row_i = y_row_i | 16'(ym[k][r] << (r*b));
    end
  endtask

  task automatic run_prod(input int code, input bit gaps, input bit joint, input bit maxv, input string tag);
    int b;
    int h;
    int mask;
    longint snap;
    bit same;
    b = width_of(code);
    h = 16 / b;
    mask = (b == 16) ? 32'hFFFF : ((1 << b) - 1);
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        xm[r][c] = maxv ? mask : int'($urandom) & mask;
        ym[r][c] = maxv ? mask : int'($urandom) & mask;
      end
    end
    for (int l = 0; l < 16; l++) begin
      expv[l] = 0;
      if (l < h*h)
        for (int k = 0; k < h; k++) expv[l] += longint'(xm[l/h][k]) * longint'(ym[k][l%h]);
    end
    if (!joint) begin
      start_i = 1'b1; prec_i = 2'(code); valid_i = 1'b0;
      @(negedge clk);
    end
    for (int k = 0; k < h; k++) begin
      if (gaps && k > 0) begin
        start_i = 1'b0; valid_i = 1'b0; prec_i = 2'($urandom);
        @(negedge clk);
      end
      start_i = joint && (k == 0);
      prec_i  = start_i ? 2'(code) : 2'($urandom);  // R6: scrambled between starts
      drive_pair(k, b, h);
      valid_i = 1'b1;
      @(negedge clk);
    end
    start_i = 1'b0; valid_i = 1'b0; prec_i = 2'($urandom);
    chk(done_o == 1'b0, "R5 early done", longint'(done_o), 0);
    @(negedge clk);
    chk(done_o == 1'b1, "R5 done pulse", longint'(done_o), 1);
    for (int l = 0; l < 16; l++) chk(lane(l) == expv[l], "R3 lane", lane(l), expv[l]);
    chk(lane(0) == expv[0], tag, lane(0), expv[0]);
    snap = lane(0);
    @(negedge clk);
    chk(done_o == 1'b0, "R5 single pulse", longint'(done_o), 0);
    // R7: surplus pair after completion
    x_col_i = 16'($urandom); y_row_i = 16'($urandom) | 16'h1111; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    repeat (2) @(negedge clk);
    same = 1'b1;
    for (int l = 0; l < 16; l++) if (lane(l) != expv[l]) same = 1'b0;
    chk(same && done_o == 1'b0, "R7 surplus ignored", lane(0), snap);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; valid_i = 1'b0; prec_i = '0;
    x_col_i = '0; y_row_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_o == 1'b0, "R1 reset done", longint'(done_o), 0);
    chk(res_o == '0, "R1 reset lanes", lane(0), 0);
    x_col_i = 16'hFFFF; y_row_i = 16'hFFFF; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(res_o == '0 && done_o == 1'b0, "R1 pair before start", lane(0), 0);

    for (int code = 0; code < 4; code++) begin
      for (int rep = 0; rep < 6; rep++) begin
        string tag;
        tag = (rep[1]) ? "R4 joint start" : (rep[0]) ? "R8 gapped pairs" :
              (code == 3) ? "R2 code 3" : "R6 prec ignored";
        run_prod(code, rep[0], rep[1], rep == 5, tag);
      end
    end

    // R9: abandon an unfinished product, last stray pair still in flight
    for (int code = 0; code < 2; code++) begin
      start_i = 1'b1; prec_i = 2'(code); valid_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0; x_col_i = 16'hFFFF; y_row_i = 16'hFFFF; valid_i = 1'b1;
      @(negedge clk);
      run_prod(code, 1'b0, 1'b1, 1'b0, "R9 abandon joint");
      start_i = 1'b1; prec_i = 2'(code); valid_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0; x_col_i = 16'hFFFF; y_row_i = 16'hFFFF; valid_i = 1'b1;
      @(negedge clk);
      run_prod(code, 1'b0, 1'b0, 1'b0, "R9 abandon restart");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog act=%0d exp=%0d", WD, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule